// File: doc/BRIEF.md
# Interrupt End-of-Service Priority Tracker

This block sits on the processor side of a memory-mapped interrupt controller and follows every interrupt from acknowledge to completion. Each acknowledge of a real interrupt pushes its identifier, its 8-bit priority and its group onto a stack of active entries. The priority of the top entry is the running priority, which upstream arbitration uses to decide whether a new interrupt may preempt. When no interrupt is active, the running priority is 0xFF.

Software finishes an interrupt by writing its identifier to the completion register at offset 0x010. That write always drops the running priority by removing the top entry. A per-group split bit then decides whether the same write also deactivates the interrupt. When the split bit is 1, deactivation is a separate step: a write of the identifier to the deactivate register at offset 0x020. Completions must come back in the reverse order of the acknowledges. A completion that breaks this order, or that arrives when nothing is active, raises a one-cycle error pulse and changes nothing else.

The write's security attribute and the security-disable bit together select the group a write acts on and the split bit that applies. A three-state machine tracks how full the stack is:
- `ST_EMPTY` goes to `ST_ACTIVE` on a push.
- `ST_ACTIVE` goes to `ST_EMPTY` when the last entry is popped.
- `ST_ACTIVE` goes to `ST_FULL` when a push fills the last slot.
- `ST_FULL` goes back to `ST_ACTIVE` on a pop.

When an acknowledge and a matching completion arrive in the same cycle, the pop happens first and the push then replaces the top entry.

Top module: `irq_eoi_tracker`

## Requirements
- R1: After reset the stack is empty, `run_prio` is 0xFF, and `deact_valid` and `err_pulse` are low.
- R2: An acknowledge with a non-reserved ID pushes an entry while fewer than 8 are held. From the next cycle `run_prio` equals the acknowledged priority, and entries nest up to 8 deep.
- R3: A completion write to offset 0x010 whose ID (data bits [23:0]) and group match the top entry removes that entry. `run_prio` then shows the entry below it, or 0xFF when the stack becomes empty.
- R4: A matching completion with the applicable split bit at 0 raises `deact_valid` for one cycle, with `deact_id` equal to the written ID, in the cycle after the write. With the split bit at 1, no pulse is raised.
- R5: Data bits [31:24] of completion and deactivate writes have no effect.
- R6: IDs 1020 to 1023 are reserved. Acknowledging one creates no entry. A completion or deactivate write carrying one changes nothing, raises no pulse and raises no error.
- R7: A completion whose ID or group differs from the top entry raises `err_pulse` for one cycle and leaves the stack unchanged.
- R8: A completion with a non-reserved ID while the stack is empty raises `err_pulse` for one cycle and has no other effect.
- R9: A write with `wr_secure`=1, or with `sec_disable`=1, acts on group 0 and uses `split_g0`. A non-secure write with `sec_disable`=0 acts on group 1 and uses `split_g1`. An acknowledge takes its group from `ack_grp` (0 or 1).
- R10: A deactivate write to offset 0x020 with the applicable split bit at 1 pulses `deact_valid` and `deact_id` for its ID in the next cycle, without touching the stack. With the split bit at 0, the write is ignored.
- R11: An acknowledge while 8 entries are held raises `err_pulse` and is dropped; the stack and `run_prio` are unchanged.
- R12: Writes to any other offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Write data; ID in bits [23:0] |
| wr_secure | input | 1 | Write is secure |
| sec_disable | input | 1 | Security disabled |
| split_g0 | input | 1 | Group 0 split drop and deactivate |
| split_g1 | input | 1 | Group 1 split drop and deactivate |
| ack_valid | input | 1 | Acknowledge event |
| ack_id | input | 24 | Acknowledged interrupt ID |
| ack_prio | input | 8 | Acknowledged interrupt priority |
| ack_grp | input | 1 | Acknowledged interrupt group |
| run_prio | output | 8 | Running priority, 0xFF when idle |
| deact_valid | output | 1 | Deactivate pulse |
| deact_id | output | 24 | ID being deactivated |
| err_pulse | output | 1 | Ordering or capacity error pulse |

## Verification
A wrong stack depth or a corrupted entry shows up on `run_prio` in the cycle after the acknowledge or completion that caused it. It also shows up at the next completion, as an unexpected `err_pulse` or a missing `deact_valid`. A fill-to-capacity pass followed by a full drain exposes slot indexing faults within 17 operations. Mismatch, empty, reserved-ID and security-routing cases each check both the error pulse and the following `run_prio`. A fault that wrongly pops or ignores an entry therefore surfaces on the same vector that caused it.

// File: rtl/irq_eoi_pkg.sv
package irq_eoi_pkg;

    localparam int ID_W   = 24;
    localparam int PRIO_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ID_W-1:0]   RSV_LO    = ID_W'(1020);
    localparam logic [ID_W-1:0]   RSV_HI    = ID_W'(1023);
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    typedef struct packed {
        logic              grp;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } act_entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FULL   = 2'd2
    } trk_state_e;

    function automatic logic id_reserved(input logic [ID_W-1:0] id);
        return (id >= RSV_LO) && (id <= RSV_HI);
    endfunction

endpackage

// File: rtl/irq_eoi_decode.sv
module irq_eoi_decode
    import irq_eoi_pkg::*;
#(
    parameter int              ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] EOI_OFS = 12'h010,
    parameter logic [ADDR_W-1:0] DIR_OFS = 12'h020
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_secure,
    input  logic              sec_disable,
    input  logic              split_g0,
    input  logic              split_g1,
    output logic              eoi_req,
    output logic              dir_req,
    output logic [ID_W-1:0]   wr_id,
    output logic              wr_grp,
    output logic              wr_split
);

    logic [DATA_W-ID_W-1:0] unused_hi;

    always_comb begin
        eoi_req   = wr_en && (wr_addr == EOI_OFS);
        dir_req   = wr_en && (wr_addr == DIR_OFS);
        wr_id     = wr_data[ID_W-1:0];
        unused_hi = wr_data[DATA_W-1:ID_W];
        // group 0 when secure or security is off, else group 1
        wr_grp    = !(wr_secure || sec_disable);
        wr_split  = wr_grp ? split_g1 : split_g0;
    end

endmodule

// File: rtl/irq_eoi_stack.sv
module irq_eoi_stack
    import irq_eoi_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  act_entry_t       push_entry,
    output act_entry_t       top,
    output logic [PTR_W-1:0] depth
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    act_entry_t slot_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        act_entry_t slot_q;
        logic       load;

        // plain push fills slot[depth]; push with pop overwrites the top slot
        assign load = (push && !pop && (depth == PTR_W'(i))) ||
                      (push &&  pop && (depth == PTR_W'(i + 1)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (load) begin
                slot_q <= push_entry;
            end
        end

        assign slot_arr[i] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (push && !pop) begin
            depth <= depth + ONE;
        end else if (pop && !push) begin
            depth <= depth - ONE;
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth == PTR_W'(i + 1)) begin
                top = slot_arr[i];
            end
        end
    end

endmodule

// File: rtl/irq_eoi_ctrl.sv
module irq_eoi_ctrl
    import irq_eoi_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_req,
    input  logic             dir_req,
    input  logic [ID_W-1:0]  wr_id,
    input  logic             wr_grp,
    input  logic             wr_split,
    input  logic             ack_valid,
    input  logic [ID_W-1:0]  ack_id,
    input  logic [PTR_W-1:0] depth,
    input  act_entry_t       top,
    output logic             push,
    output logic             pop,
    output trk_state_e       state,
    output logic             deact_valid,
    output logic [ID_W-1:0]  deact_id,
    output logic             err_pulse
);

    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    trk_state_e state_q, state_d;
    logic       wr_rsv, ack_rsv, match;
    logic       err_d, dv_d;

    always_comb begin
        wr_rsv  = id_reserved(wr_id);
        ack_rsv = id_reserved(ack_id);
        match   = (state_q != ST_EMPTY) && (top.id == wr_id) && (top.grp == wr_grp);
        pop     = eoi_req && !wr_rsv && match;
        push    = ack_valid && !ack_rsv && ((state_q != ST_FULL) || pop);
        err_d   = (eoi_req && !wr_rsv && !match) ||
                  (ack_valid && !ack_rsv && !push);
        dv_d    = (pop && !wr_split) || (dir_req && !wr_rsv && wr_split);

        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) begin
                    state_d = (DEPTH == 1) ? ST_FULL : ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (pop && !push && (depth == ONE)) begin
                    state_d = ST_EMPTY;
                end else if (push && !pop && (depth == LAST)) begin
                    state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (pop && !push) begin
                    state_d = (DEPTH == 1) ? ST_EMPTY : ST_ACTIVE;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deact_valid <= 1'b0;
            deact_id    <= '0;
            err_pulse   <= 1'b0;
        end else begin
            deact_valid <= dv_d;
            deact_id    <= dv_d ? wr_id : '0;
            err_pulse   <= err_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/irq_eoi_tracker.sv
module irq_eoi_tracker
    import irq_eoi_pkg::*;
#(
    parameter  int                DEPTH   = 8,
    parameter  int                ADDR_W  = 12,
    parameter  logic [ADDR_W-1:0] EOI_OFS = 12'h010,
    parameter  logic [ADDR_W-1:0] DIR_OFS = 12'h020,
    localparam int                PTR_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              wr_secure,
    input  logic              sec_disable,
    input  logic              split_g0,
    input  logic              split_g1,
    input  logic              ack_valid,
    input  logic [23:0]       ack_id,
    input  logic [7:0]        ack_prio,
    input  logic              ack_grp,
    output logic [7:0]        run_prio,
    output logic              deact_valid,
    output logic [23:0]       deact_id,
    output logic              err_pulse
);

    logic             eoi_req, dir_req, wr_grp, wr_split;
    logic [ID_W-1:0]  wr_id;
    logic             push, pop;
    logic [PTR_W-1:0] depth;
    act_entry_t       top, new_entry;
    trk_state_e       state;

    irq_eoi_decode #(
        .ADDR_W  (ADDR_W),
        .EOI_OFS (EOI_OFS),
        .DIR_OFS (DIR_OFS)
    ) u_decode (
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_secure   (wr_secure),
        .sec_disable (sec_disable),
        .split_g0    (split_g0),
        .split_g1    (split_g1),
        .eoi_req     (eoi_req),
        .dir_req     (dir_req),
        .wr_id       (wr_id),
        .wr_grp      (wr_grp),
        .wr_split    (wr_split)
    );

    assign new_entry = '{grp: ack_grp, prio: ack_prio, id: ack_id};

    irq_eoi_stack #(
        .DEPTH (DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_entry (new_entry),
        .top        (top),
        .depth      (depth)
    );

    irq_eoi_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoi_req     (eoi_req),
        .dir_req     (dir_req),
        .wr_id       (wr_id),
        .wr_grp      (wr_grp),
        .wr_split    (wr_split),
        .ack_valid   (ack_valid),
        .ack_id      (ack_id),
        .depth       (depth),
        .top         (top),
        .push        (push),
        .pop         (pop),
        .state       (state),
        .deact_valid (deact_valid),
        .deact_id    (deact_id),
        .err_pulse   (err_pulse)
    );

    assign run_prio = (depth == '0) ? IDLE_PRIO : top.prio;

endmodule

// File: rtl/irq_eoi_tracker_chk.sv
module irq_eoi_tracker_chk
    import irq_eoi_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eoi_req,
    input logic             wr_split,
    input logic [ID_W-1:0]  wr_id,
    input logic             ack_valid,
    input logic [ID_W-1:0]  ack_id,
    input logic             push,
    input logic             pop,
    input logic [PTR_W-1:0] depth,
    input trk_state_e       state,
    input logic [7:0]       run_prio,
    input logic             deact_valid,
    input logic             err_pulse
);

    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    a_r1_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (run_prio == 8'hFF));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (depth <= FULL));

    a_r11_full_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (depth == FULL));

    a_r3_pop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (depth == $past(depth) - ONE));

    a_r7_err_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !pop && !push) |=> (depth == $past(depth)));

    a_r6_rsv_ack_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && id_reserved(ack_id) && !pop) |=> $stable(depth));

    a_r4_split_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && wr_split) |=> !deact_valid);

    a_r8_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && eoi_req && !id_reserved(wr_id)) |=> err_pulse);

endmodule

bind irq_eoi_tracker irq_eoi_tracker_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoi_req     (eoi_req),
    .wr_split    (wr_split),
    .wr_id       (wr_id),
    .ack_valid   (ack_valid),
    .ack_id      (ack_id),
    .push        (push),
    .pop         (pop),
    .depth       (depth),
    .state       (state),
    .run_prio    (run_prio),
    .deact_valid (deact_valid),
    .err_pulse   (err_pulse)
);

// File: tb/irq_eoi_tracker_bench.sv
`timescale 1ns/1ps
module irq_eoi_tracker_bench;

    localparam logic [1:0] OP_ACK = 2'd0;
    localparam logic [1:0] OP_EOI = 2'd1;
    localparam logic [1:0] OP_DIR = 2'd2;
    localparam logic [1:0] OP_OTH = 2'd3;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  op;
        logic        sec;
        logic        sdis;
        logic        m0;
        logic        m1;
        logic        grp;
        logic [7:0]  hi;
        logic [23:0] id;
        logic [7:0]  prio;
        logic        dv;
        logic        err;
        logic [7:0]  rp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  OP_ACK, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd40,   8'h80, 1'b0, 1'b0, 8'h80}, // R2
        '{8'd2,  OP_ACK, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd41,   8'h40, 1'b0, 1'b0, 8'h40}, // R2 nest
        '{8'd7,  OP_EOI, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd40,   8'h00, 1'b0, 1'b1, 8'h40}, // R7 wrong order
        '{8'd4,  OP_EOI, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd41,   8'h00, 1'b1, 1'b0, 8'h80}, // R3 R4 drop+deact
        '{8'd5,  OP_EOI, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 24'd40,   8'h00, 1'b0, 1'b0, 8'hFF}, // R5 R4 split
        '{8'd10, OP_DIR, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 24'd40,   8'h00, 1'b1, 1'b0, 8'hFF}, // R10 deact
        '{8'd10, OP_DIR, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd40,   8'h00, 1'b0, 1'b0, 8'hFF}, // R10 ignored
        '{8'd8,  OP_EOI, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd7,    8'h00, 1'b0, 1'b1, 8'hFF}, // R8 empty
        '{8'd6,  OP_ACK, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd1021, 8'h10, 1'b0, 1'b0, 8'hFF}, // R6 rsv ack
        '{8'd6,  OP_EOI, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd1021, 8'h00, 1'b0, 1'b0, 8'hFF}, // R6 rsv eoi
        '{8'd6,  OP_DIR, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 24'd1022, 8'h00, 1'b0, 1'b0, 8'hFF}, // R6 rsv dir
        '{8'd9,  OP_ACK, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 24'd300,  8'h60, 1'b0, 1'b0, 8'h60}, // R9 grp1
        '{8'd9,  OP_EOI, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd300,  8'h00, 1'b0, 1'b1, 8'h60}, // R9 grp0 miss
        '{8'd9,  OP_EOI, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 24'd300,  8'h00, 1'b1, 1'b0, 8'hFF}, // R9 split_g1
        '{8'd9,  OP_ACK, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 24'd500,  8'h20, 1'b0, 1'b0, 8'h20}, // R9
        '{8'd9,  OP_EOI, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 24'd500,  8'h00, 1'b1, 1'b0, 8'hFF}, // R9 sdis
        '{8'd2,  OP_ACK, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd9,    8'h30, 1'b0, 1'b0, 8'h30}, // R2
        '{8'd12, OP_OTH, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 24'd9,    8'h00, 1'b0, 1'b0, 8'h30}, // R12
        '{8'd5,  OP_EOI, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 24'd9,    8'h00, 1'b1, 1'b0, 8'hFF}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_secure = 1'b0;
    logic        sec_disable = 1'b0;
    logic        split_g0 = 1'b0;
    logic        split_g1 = 1'b0;
    logic        ack_valid = 1'b0;
    logic [23:0] ack_id = '0;
    logic [7:0]  ack_prio = '0;
    logic        ack_grp = 1'b0;
    logic [7:0]  run_prio;
    logic        deact_valid;
    logic [23:0] deact_id;
    logic        err_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_eoi_tracker u_irq_eoi_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_secure   (wr_secure),
        .sec_disable (sec_disable),
        .split_g0    (split_g0),
        .split_g1    (split_g1),
        .ack_valid   (ack_valid),
        .ack_id      (ack_id),
        .ack_prio    (ack_prio),
        .ack_grp     (ack_grp),
        .run_prio    (run_prio),
        .deact_valid (deact_valid),
        .deact_id    (deact_id),
        .err_pulse   (err_pulse)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // drive one operation for one cycle, then release; outputs are then valid
    task automatic apply(input vec_t v);
        @(negedge clk);
        wr_secure   = v.sec;
        sec_disable = v.sdis;
        split_g0    = v.m0;
        split_g1    = v.m1;
        if (v.op == OP_ACK) begin
            ack_valid = 1'b1;
            ack_id    = v.id;
            ack_prio  = v.prio;
            ack_grp   = v.grp;
        end else begin
            wr_en   = 1'b1;
            wr_addr = (v.op == OP_EOI) ? 12'h010 : (v.op == OP_DIR) ? 12'h020 : 12'h014;
            wr_data = {v.hi, v.id};
        end
        @(negedge clk);
        wr_en     = 1'b0;
        ack_valid = 1'b0;
    endtask

    task automatic check_vec(input string tag, input vec_t v);
        check($sformatf("%s deact_valid", tag), {31'd0, deact_valid}, {31'd0, v.dv});
        if (v.dv) check($sformatf("%s deact_id", tag), {8'd0, deact_id}, {8'd0, v.id});
        check($sformatf("%s err_pulse", tag), {31'd0, err_pulse}, {31'd0, v.err});
        check($sformatf("%s run_prio", tag), {24'd0, run_prio}, {24'd0, v.rp});
    endtask

    function automatic vec_t mk(input logic [1:0] op, input logic [23:0] id,
                                input logic [7:0] prio, input logic dv,
                                input logic err, input logic [7:0] rp);
        vec_t v;
        v = '0;
        v.op = op; v.sec = 1'b1; v.id = id; v.prio = prio;
        v.dv = dv; v.err = err; v.rp = rp;
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 run_prio", {24'd0, run_prio}, 32'hFF);
        check("R1 deact_valid", {31'd0, deact_valid}, 32'd0);
        check("R1 err_pulse", {31'd0, err_pulse}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check_vec($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i]);
        end

        // R11: fill to 8, overflow, then drain in reverse (R2 R3 R4)
        for (int i = 0; i < 8; i++) begin
            apply(mk(OP_ACK, 24'(100 + i), 8'(8'h70 - i), 1'b0, 1'b0, 8'(8'h70 - i)));
            check_vec("R2 fill", mk(OP_ACK, 24'(100 + i), 8'(8'h70 - i), 1'b0, 1'b0, 8'(8'h70 - i)));
        end
        apply(mk(OP_ACK, 24'd200, 8'h10, 1'b0, 1'b1, 8'h69));
        check_vec("R11 overflow", mk(OP_ACK, 24'd200, 8'h10, 1'b0, 1'b1, 8'h69));
        apply(mk(OP_EOI, 24'd200, 8'h00, 1'b0, 1'b1, 8'h69));
        check_vec("R11 dropped entry", mk(OP_EOI, 24'd200, 8'h00, 1'b0, 1'b1, 8'h69));
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] exp_rp;
            exp_rp = (i == 0) ? 8'hFF : 8'(8'h70 - (i - 1));
            apply(mk(OP_EOI, 24'(100 + i), 8'h00, 1'b1, 1'b0, exp_rp));
            check_vec("R3 drain", mk(OP_EOI, 24'(100 + i), 8'h00, 1'b1, 1'b0, exp_rp));
        end

        // R1: reset while entries are active
        apply(mk(OP_ACK, 24'd55, 8'h22, 1'b0, 1'b0, 8'h22));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run run_prio", {24'd0, run_prio}, 32'hFF);
        rst_n = 1'b1;
        apply(mk(OP_EOI, 24'd55, 8'h00, 1'b0, 1'b1, 8'hFF));
        check_vec("R1 R8 after reset", mk(OP_EOI, 24'd55, 8'h00, 1'b0, 1'b1, 8'hFF));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule